// File: doc/BRIEF.md
# Dual-Pixel Sprite Line Serializer

This block takes one 32-bit graphics word that encodes a whole 8-pixel sprite line at 4 bits per pixel. It plays that line out as a stream of pixel pairs, one pair per clock, on two 4-bit color outputs called A and B. Each output has an opacity flag that is low for the transparent color 0. A flip input mirrors the line horizontally. A swap input exchanges the two output lanes, so the pair can be aligned to even or odd screen columns.

State (the stored word, the step counter and an active flag) advances on the rising edge of `clk`. The output pair is registered on the falling edge, from the state that the preceding rising edge set up. A load pulse seen on a rising edge captures `din` and presents step 0 at the next falling edge. Each later rising edge moves one step on. After the fourth pair the outputs go transparent until the next load.

The pixel stream has no back-pressure: once loaded, the block emits one pair per clock and cannot be stalled. The producer reloads by pulsing `load` in any cycle. No handshake is offered, and a load is never refused.

Top module: `sprite_pair_serializer`

## Requirements
- R1: A high `rst` on a rising edge clears the stored line. From the following falling edge, both colors read 0 and both opacity flags read low until a load is captured.
- R2: Pixel k (0..7) takes color bit j (0..3) from `din` bit 8*j+k, so byte 0 holds bit 0 of every pixel and byte 3 holds bit 3.
- R3: With `flip` and `swap` low, the pair shown after the falling edge that follows the s-th rising edge after the load edge (s = 0..3, the load edge counting as s = 0) is pixel 2s on A and pixel 2s+1 on B.
- R4: With `flip` high and `swap` low, step s shows pixel 7-2s on A and pixel 6-2s on B.
- R5: With `swap` high and `flip` low, step s shows pixel 2s+1 on A and pixel 2s on B.
- R6: Each opacity flag is high exactly when the color on its own lane is nonzero. A line word of zero therefore gives two transparent outputs.
- R7: Once all four pairs of a line have been shown, and with no new load, both outputs stay at color 0 with both flags low.
- R8: A load captured while a line is still playing discards the rest of that line. The new line starts at step 0 on the next falling edge.
- R9: With both `flip` and `swap` high, step s shows pixel 6-2s on A and pixel 7-2s on B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock. State moves on the rising edge and outputs on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Captures `din` and restarts the line at step 0 |
| din | input | 32 | Line word holding eight 4-bit pixels, arranged as bit planes by byte |
| flip | input | 1 | Reverses the order in which pixels leave |
| swap | input | 1 | Exchanges the pixels on lanes A and B |
| pix_a | output | 4 | Color of lane A |
| pix_b | output | 4 | Color of lane B |
| opaque_a | output | 1 | High when `pix_a` is nonzero |
| opaque_b | output | 1 | High when `pix_b` is nonzero |

## Verification
The assertions assume that `rst`, `load` and `din` are synchronous to the rising edge and steady around it. They also assume that reset is held across at least one rising edge, so the falling-edge output register has already been cleared when the properties are first enabled. The stimulus moves every input one nanosecond after a falling edge, well clear of both edges. It holds `flip` and `swap` constant for the whole of each line, because the lane mapping follows those inputs live rather than latching them at load time.

// File: rtl/sps_pkg.sv
package sps_pkg;

  // Position within the line of the pixel that lane `lane` carries at step `step`.
  function automatic int pixel_slot(input int step, input int lane, input logic rev,
                                    input int lanes, input int ppl);
    int fwd;
    fwd = step * lanes + lane;
    return rev ? (ppl - 1 - fwd) : fwd;
  endfunction

endpackage

// File: rtl/sps_line_store.sv
module sps_line_store #(
  parameter int WORD_W = 32,
  parameter int STEPS  = 4,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word_q,
  output logic [STEP_W-1:0] step_q,
  output logic              active_q
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      step_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      word_q   <= din;
      step_q   <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (step_q == LAST_STEP) begin
        active_q <= 1'b0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sps_pair_select.sv
module sps_pair_select #(
  parameter int PIX_BITS = 4,
  parameter int PPL      = 8,
  parameter int LANES    = 2,
  parameter int STEP_W   = 2
) (
  input  logic [PIX_BITS*PPL-1:0]   word,
  input  logic [STEP_W-1:0]         step,
  input  logic                      active,
  input  logic                      flip,
  input  logic                      swap,
  output logic [LANES*PIX_BITS-1:0] colors
);

  localparam int IDX_W = (PPL > 1) ? $clog2(PPL) : 1;

  logic [PIX_BITS-1:0] pix [PPL];
  logic [PIX_BITS-1:0] raw [LANES];

  // Bit-plane layout: plane j lives in slice j of the word, one bit per pixel.
  for (genvar k = 0; k < PPL; k++) begin : g_pix
    for (genvar j = 0; j < PIX_BITS; j++) begin : g_plane
      assign pix[k][j] = word[j*PPL + k];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign idx    = IDX_W'(sps_pkg::pixel_slot(int'(step), l, flip, LANES, PPL));
    assign raw[l] = active ? pix[idx] : '0;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_route
    assign colors[l*PIX_BITS +: PIX_BITS] = swap ? raw[LANES-1-l] : raw[l];
  end

endmodule

// File: rtl/sps_pair_out.sv
module sps_pair_out #(
  parameter int PIX_BITS = 4,
  parameter int LANES    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*PIX_BITS-1:0] colors,
  output logic [LANES*PIX_BITS-1:0] color_q,
  output logic [LANES-1:0]          opaque_q
);

  always_ff @(negedge clk) begin
    if (rst) begin
      color_q  <= '0;
      opaque_q <= '0;
    end else begin
      color_q <= colors;
      for (int l = 0; l < LANES; l++) begin
        opaque_q[l] <= |colors[l*PIX_BITS +: PIX_BITS];
      end
    end
  end

endmodule

// File: rtl/sprite_pair_serializer.sv
module sprite_pair_serializer #(
  parameter int PIX_BITS     = 4,
  parameter int PIX_PER_LINE = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [PIX_BITS*PIX_PER_LINE-1:0] din,
  input  logic                           flip,
  input  logic                           swap,
  output logic [PIX_BITS-1:0]            pix_a,
  output logic [PIX_BITS-1:0]            pix_b,
  output logic                           opaque_a,
  output logic                           opaque_b
);

  localparam int LANES  = 2;
  localparam int WORD_W = PIX_BITS * PIX_PER_LINE;
  localparam int STEPS  = PIX_PER_LINE / LANES;
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [WORD_W-1:0]         word_q;
  logic [STEP_W-1:0]         step_q;
  logic                      active_q;
  logic [LANES*PIX_BITS-1:0] colors;
  logic [LANES*PIX_BITS-1:0] color_q;
  logic [LANES-1:0]          opaque_q;

  sps_line_store #(
    .WORD_W (WORD_W),
    .STEPS  (STEPS),
    .STEP_W (STEP_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .din      (din),
    .word_q   (word_q),
    .step_q   (step_q),
    .active_q (active_q)
  );

  sps_pair_select #(
    .PIX_BITS (PIX_BITS),
    .PPL      (PIX_PER_LINE),
    .LANES    (LANES),
    .STEP_W   (STEP_W)
  ) u_select (
    .word   (word_q),
    .step   (step_q),
    .active (active_q),
    .flip   (flip),
    .swap   (swap),
    .colors (colors)
  );

  sps_pair_out #(
    .PIX_BITS (PIX_BITS),
    .LANES    (LANES)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .colors   (colors),
    .color_q  (color_q),
    .opaque_q (opaque_q)
  );

  assign pix_a    = color_q[0 +: PIX_BITS];
  assign pix_b    = color_q[PIX_BITS +: PIX_BITS];
  assign opaque_a = opaque_q[0];
  assign opaque_b = opaque_q[1];

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int PIX_BITS     = 4,
  parameter int PIX_PER_LINE = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             load,
  input logic [PIX_BITS*PIX_PER_LINE-1:0] din,
  input logic [PIX_BITS-1:0]              pix_a,
  input logic [PIX_BITS-1:0]              pix_b,
  input logic                             opaque_a,
  input logic                             opaque_b
);

  localparam int STEPS = PIX_PER_LINE / 2;
  localparam int GW    = $clog2(STEPS + 1);

  logic [GW-1:0] gap;
  logic          dark;

  // Edges since the last load, saturating at STEPS (line finished).
  always_ff @(posedge clk) begin
    if (rst)                  gap <= GW'(STEPS);
    else if (load)            gap <= '0;
    else if (gap < GW'(STEPS)) gap <= gap + 1'b1;
  end

  assign dark = (pix_a == '0) && (pix_b == '0) && !opaque_a && !opaque_b;

  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> dark);

  p_opaque_a_r6: assert property (@(posedge clk) disable iff (rst)
    opaque_a == (pix_a != '0));

  p_opaque_b_r6: assert property (@(posedge clk) disable iff (rst)
    opaque_b == (pix_b != '0));

  p_zero_line_dark_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(load) && ($past(din) == '0)) |-> dark);

  p_idle_after_line_r7: assert property (@(posedge clk) disable iff (rst)
    (gap >= GW'(STEPS)) |-> dark);

endmodule

bind sprite_pair_serializer sps_checker #(
  .PIX_BITS     (PIX_BITS),
  .PIX_PER_LINE (PIX_PER_LINE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .din      (din),
  .pix_a    (pix_a),
  .pix_b    (pix_b),
  .opaque_a (opaque_a),
  .opaque_b (opaque_b)
);

// File: tb/sprite_pair_serializer_tb.sv
`timescale 1ns/1ps
module sprite_pair_serializer_tb;

  localparam real PERIOD = 5.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [31:0] din = '0;
  logic        flip = 1'b0;
  logic        swap = 1'b0;
  logic [3:0]  pix_a, pix_b;
  logic        opaque_a, opaque_b;

  int checks = 0;
  int failures = 0;

  always #(PERIOD/2) clk = ~clk;

  sprite_pair_serializer u_dut (
    .clk(clk), .rst(rst), .load(load), .din(din), .flip(flip), .swap(swap),
    .pix_a(pix_a), .pix_b(pix_b), .opaque_a(opaque_a), .opaque_b(opaque_b)
  );

  // Stimulus vectors: {line word, flip, swap}
  localparam int NVEC = 8;
  localparam logic [33:0] VEC [NVEC] = '{
    {32'h0000_0001, 1'b0, 1'b0},
    {32'h8000_0000, 1'b0, 1'b0},
    {32'h1234_5678, 1'b0, 1'b0},
    {32'h1234_5678, 1'b1, 1'b0},
    {32'h1234_5678, 1'b0, 1'b1},
    {32'h1234_5678, 1'b1, 1'b1},
    {32'hA5C3_0FF0, 1'b1, 1'b0},
    {32'h0000_00F0, 1'b0, 1'b1}
  };

  // R2: pixel k, color bit j comes from word bit 8*j+k
  function automatic logic [3:0] px(input logic [31:0] w, input int k);
    return {w[24+k], w[16+k], w[8+k], w[k]};
  endfunction

  function automatic logic [7:0] exp_pair(input logic [31:0] w, input int s,
                                          input logic f, input logic sw);
    int ia, ib;
    ia = f ? 7 - 2*s : 2*s;
    ib = f ? 6 - 2*s : 2*s + 1;
    return sw ? {px(w, ia), px(w, ib)} : {px(w, ib), px(w, ia)}; // {B, A}
  endfunction

  task automatic expect_pair(input string req, input logic [3:0] ea, input logic [3:0] eb);
    logic oa, ob;
    oa = (ea != 4'd0);
    ob = (eb != 4'd0);
    checks++;
    if (pix_a !== ea || pix_b !== eb || opaque_a !== oa || opaque_b !== ob) begin
      failures++;
      $display("FAIL %s: actual a=%h b=%h oa=%b ob=%b expected a=%h b=%h oa=%b ob=%b",
               req, pix_a, pix_b, opaque_a, opaque_b, ea, eb, oa, ob);
    end
  endtask

  task automatic step_wait();
    @(negedge clk);
    #1;
  endtask

  task automatic run_line(input logic [31:0] w, input logic f, input logic sw, input string req);
    logic [7:0] e;
    load = 1'b1; din = w; flip = f; swap = sw;
    for (int s = 0; s < 4; s++) begin
      step_wait();
      load = 1'b0;
      e = exp_pair(w, s, f, sw);
      expect_pair(req, e[3:0], e[7:4]);
    end
  endtask

  function automatic string req_of(input logic [31:0] w, input logic f, input logic sw);
    if (w == 32'h0000_0001 || w == 32'h8000_0000) return "R2";
    if (w == 32'h0000_00F0) return "R6";
    if (f && sw) return "R9";
    if (f) return "R4";
    if (sw) return "R5";
    return "R3";
  endfunction

  initial begin : watchdog
    #(200000 * PERIOD);
    failures++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] e;
    // R1: reset state
    step_wait();
    step_wait();
    expect_pair("R1", 4'd0, 4'd0);
    rst = 1'b0;
    step_wait();
    expect_pair("R1", 4'd0, 4'd0);

    // Table walk, lines back to back
    for (int v = 0; v < NVEC; v++) begin
      run_line(VEC[v][33:2], VEC[v][1], VEC[v][0],
               req_of(VEC[v][33:2], VEC[v][1], VEC[v][0]));
    end

    // R7: idle after last pair
    for (int i = 0; i < 3; i++) begin
      step_wait();
      expect_pair("R7", 4'd0, 4'd0);
    end

    // R8: reload in the middle of a line
    load = 1'b1; din = 32'hFFFF_FFFF; flip = 1'b0; swap = 1'b0;
    step_wait();
    load = 1'b0;
    expect_pair("R8", 4'hF, 4'hF);
    step_wait();
    expect_pair("R8", 4'hF, 4'hF);
    load = 1'b1; din = 32'h1234_5678;
    for (int s = 0; s < 4; s++) begin
      step_wait();
      load = 1'b0;
      e = exp_pair(32'h1234_5678, s, 1'b0, 1'b0);
      expect_pair("R8", e[3:0], e[7:4]);
    end
    step_wait();
    expect_pair("R7", 4'd0, 4'd0);

    // R6: all-zero word is transparent
    load = 1'b1; din = 32'h0;
    step_wait();
    load = 1'b0;
    expect_pair("R6", 4'd0, 4'd0);

    // R1: reset in the middle of a line
    load = 1'b1; din = 32'hFFFF_FFFF;
    step_wait();
    load = 1'b0;
    expect_pair("R3", 4'hF, 4'hF);
    rst = 1'b1;
    step_wait();
    expect_pair("R1", 4'd0, 4'd0);
    rst = 1'b0;
    step_wait();
    expect_pair("R1", 4'd0, 4'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule